// File: doc/BRIEF.md
# Phase-Offset Programmable Post-Divider

This block divides a fast input clock by one of eleven ratios and drives one bank of outputs with the divided waveform. It runs entirely in the fast clock domain. A modulo counter steps once per input cycle, and the output level is decoded from the counter position. At ratio 1 the output is a level that stays high every cycle, so it works as a clock enable.

Several banks can be aligned to one another. All instances receive the same one-cycle `sync_load` pulse. On that pulse each instance captures its ratio and phase settings and preloads its counter. Banks programmed with a phase of zero start at position 0. A bank with a nonzero phase starts further along the period, so its edges lead those of the zero-phase banks from the very first cycle. The phase step depends on the ratio:

- For power-of-two ratios, one step is one input cycle.
- For ratios that are multiples of five, one step is five input cycles.

Settings written between pulses do not disturb the running waveform.

Top module: `phase_post_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` is 0. After reset the block runs at ratio 1 with zero offset, so `div_out` follows `bank_en` with one cycle of delay until the first `sync_load`.
- R2: On `sync_load`, `ratio_sel` picks the ratio as follows: 0→1, 1→2, 2→4, 3→5, 4→8, 5→10, 6→16, 7→20, 8→32, 9→40, 10→80. The resulting output period is that many input cycles.
- R3: Codes 11 to 15 of `ratio_sel` select ratio 1.
- R4: The counter position p runs from 0 to ratio−1 and advances by one per cycle. The output is high while p < H, where H is ratio/2 for even ratios, 2 for ratio 5 and 1 for ratio 1.
- R5: In the cycle after the `sync_load` edge, the position equals the captured offset. The offset is k phase steps, so the lead over a zero-phase bank is present from the first output edge.
- R6: For ratios 2, 4, 8, 16 and 32, k is the low 1, 2, 3, 4 or 5 bits of `phase_sel`, and the step is one input cycle. Higher bits have no effect.
- R7: For ratios 10, 20, 40 and 80, k is `phase_sel` bits [1], [2:1], [3:1] or [4:1], and the step is five input cycles. Bit 0 and any higher bits have no effect.
- R8: For ratios 1 and 5, `phase_sel` has no effect.
- R9: When `phase_en` is 0 at `sync_load`, the offset is zero whatever `phase_sel` holds.
- R10: When `bank_en` is low at a clock edge, `div_out` is low after that edge. The counter keeps running, so re-enabling resumes at the aligned phase.
- R11: Changes on `ratio_sel`, `phase_sel` and `phase_en` without `sync_load` leave the waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_load | input | 1 | One-cycle pulse that captures the settings and preloads the counter |
| ratio_sel | input | SEL_W (4) | Divide ratio code |
| phase_sel | input | PH_W (5) | Phase lead field |
| phase_en | input | 1 | Applies `phase_sel` when 1 |
| bank_en | input | 1 | Output enable for the bank; low forces the output low |
| div_out | output | 1 | Divided bank output |

## Verification
The bench builds the block with its default widths: a 4-bit code, a 5-bit phase field and a 7-bit counter. It also uses the registered output variant. With these widths every code, including the five unused ones, can be reached, along with every phase bit position at the largest ratio of 80. This covers the deepest five-cycle step offset (75 cycles) and the wrap of the counter at both extremes. Random segments mix several things:

- configuration changes made without a sync pulse;
- toggling of the bank enable;
- the disabled-phase case.

These segments run against directed cases for each ratio and each bit-masking rule.

// File: rtl/phase_post_divider_pkg.sv
package phase_post_divider_pkg;
   // Widest ratio the decoder can produce and the counter bits it needs
   localparam int unsigned LARGEST_RATIO = 80;
   localparam int unsigned MIN_CNT_W     = $clog2(LARGEST_RATIO);
   // Minimum code and phase widths the ratio table relies on
   localparam int unsigned MIN_SEL_W     = 4;
   localparam int unsigned MIN_PH_W      = 5;
   // Number of input cycles in one phase step for ratios that are multiples of five
   localparam int unsigned COARSE_STEP   = 5;

   typedef enum logic [1:0] {
      FAM_UNITY = 2'd0,   // ratio 1
      FAM_POW2  = 2'd1,   // 2,4,8,16,32
      FAM_MUL5  = 2'd2    // 5,10,20,40,80
   } ratio_family_e;
endpackage

// File: rtl/ppd_ratio_decode.sv
module ppd_ratio_decode
   import phase_post_divider_pkg::*;
#(
   parameter int unsigned SEL_W = 4,
   parameter int unsigned CNT_W = 7
) (
   input  logic [SEL_W-1:0] code,
   output logic [CNT_W-1:0] ratio,
   output logic [CNT_W-1:0] high_len,
   output ratio_family_e    family,
   output logic [2:0]       steps_log2
);
   // Selects one (ratio, family, log2 of steps per period) tuple per code
   always_comb begin
      ratio      = CNT_W'(1);
      family     = FAM_UNITY;
      steps_log2 = 3'd0;
      case (code)
         SEL_W'(0):  begin ratio = CNT_W'(1);  family = FAM_UNITY; steps_log2 = 3'd0; end
         SEL_W'(1):  begin ratio = CNT_W'(2);  family = FAM_POW2;  steps_log2 = 3'd1; end
         SEL_W'(2):  begin ratio = CNT_W'(4);  family = FAM_POW2;  steps_log2 = 3'd2; end
         SEL_W'(3):  begin ratio = CNT_W'(5);  family = FAM_MUL5;  steps_log2 = 3'd0; end
         SEL_W'(4):  begin ratio = CNT_W'(8);  family = FAM_POW2;  steps_log2 = 3'd3; end
         SEL_W'(5):  begin ratio = CNT_W'(10); family = FAM_MUL5;  steps_log2 = 3'd1; end
         SEL_W'(6):  begin ratio = CNT_W'(16); family = FAM_POW2;  steps_log2 = 3'd4; end
         SEL_W'(7):  begin ratio = CNT_W'(20); family = FAM_MUL5;  steps_log2 = 3'd2; end
         SEL_W'(8):  begin ratio = CNT_W'(32); family = FAM_POW2;  steps_log2 = 3'd5; end
         SEL_W'(9):  begin ratio = CNT_W'(40); family = FAM_MUL5;  steps_log2 = 3'd3; end
         SEL_W'(10): begin ratio = CNT_W'(80); family = FAM_MUL5;  steps_log2 = 3'd4; end
         default:    begin ratio = CNT_W'(1);  family = FAM_UNITY; steps_log2 = 3'd0; end
      endcase
   end

   // High time: half the period for even ratios, 2 of 5 for ratio 5, whole cycle for ratio 1
   always_comb begin
      if (family == FAM_UNITY)
         high_len = CNT_W'(1);
      else if (family == FAM_MUL5 && steps_log2 == 3'd0)
         high_len = CNT_W'(2);
      else
         high_len = ratio >> 1;
   end
endmodule

// File: rtl/ppd_phase_map.sv
module ppd_phase_map
   import phase_post_divider_pkg::*;
#(
   parameter int unsigned PH_W     = 5,
   parameter int unsigned CNT_W    = 7,
   parameter bit          SHIFT_ADD = 1'b1
) (
   input  logic [PH_W-1:0]  phase,
   input  logic             apply,
   input  ratio_family_e    family,
   input  logic [2:0]       steps_log2,
   output logic [CNT_W-1:0] offset
);
   logic [CNT_W-1:0] field;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] steps;
   logic [CNT_W-1:0] coarse;

   // Multiple-of-five ratios skip bit 0; the mask keeps only bits within one period
   assign field = (family == FAM_MUL5) ? CNT_W'(phase >> 1) : CNT_W'(phase);
   assign mask  = (CNT_W'(1) << steps_log2) - CNT_W'(1);
   assign steps = field & mask;

   // Five-cycle step: either a shift-and-add or a plain constant multiply
   generate
      if (SHIFT_ADD) begin : g_shift_add
         assign coarse = (steps << 2) + steps;
      end else begin : g_mult
         assign coarse = steps * CNT_W'(COARSE_STEP);
      end
   endgenerate

   always_comb begin
      if (!apply || family == FAM_UNITY)
         offset = '0;
      else if (family == FAM_MUL5)
         offset = coarse;
      else
         offset = steps;
   end
endmodule

// File: rtl/ppd_counter.sv
module ppd_counter #(
   parameter int unsigned CNT_W   = 7,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ratio_in,
   input  logic [CNT_W-1:0] high_in,
   input  logic [CNT_W-1:0] offset_in,
   input  logic             enable,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] ratio_cur,
   output logic             level
);
   logic [CNT_W-1:0] pos_q, ratio_q, high_q;
   logic [CNT_W-1:0] pos_nxt, high_nxt;
   logic             at_wrap;

   // Last position of the period for the captured ratio
   assign at_wrap  = (pos_q == ratio_q - CNT_W'(1));
   // A load preloads the phase offset and takes the new high time on the same edge
   assign pos_nxt  = load ? offset_in : (at_wrap ? '0 : pos_q + CNT_W'(1));
   assign high_nxt = load ? high_in : high_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         ratio_q <= CNT_W'(1);
         high_q  <= CNT_W'(1);
      end else begin
         pos_q <= pos_nxt;
         if (load) begin
            ratio_q <= ratio_in;
            high_q  <= high_in;
         end
      end
   end

   // Registered decode gives a glitch-free level; decoded form reuses the counter flops
   generate
      if (OUT_REG) begin : g_reg_out
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= enable && (pos_nxt < high_nxt);
         end
         assign level = lvl_q;
      end else begin : g_dec_out
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= enable;
         end
         assign level = en_q && (pos_q < high_q);
      end
   endgenerate

   assign pos       = pos_q;
   assign ratio_cur = ratio_q;
endmodule

// File: rtl/phase_post_divider.sv
module phase_post_divider
   import phase_post_divider_pkg::*;
#(
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned PH_W      = 5,
   parameter int unsigned CNT_W     = 7,
   parameter bit          OUT_REG   = 1'b1,
   parameter bit          SHIFT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_load,
   input  logic [SEL_W-1:0] ratio_sel,
   input  logic [PH_W-1:0]  phase_sel,
   input  logic             phase_en,
   input  logic             bank_en,
   output logic             div_out
);
   // Elaboration checks on the widths the ratio table needs
   generate
      if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest ratio");
      end
      if (SEL_W < MIN_SEL_W) begin : g_bad_sel
         $error("SEL_W too narrow for the ratio codes");
      end
      if (PH_W < MIN_PH_W) begin : g_bad_ph
         $error("PH_W too narrow for the phase field");
      end
   endgenerate

   logic [CNT_W-1:0] ratio_live, high_live, off_live;
   logic [CNT_W-1:0] cnt_q, ratio_q;
   ratio_family_e    fam_live;
   logic [2:0]       nlog_live;

   ppd_ratio_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_decode (
      .code       (ratio_sel),
      .ratio      (ratio_live),
      .high_len   (high_live),
      .family     (fam_live),
      .steps_log2 (nlog_live)
   );

   ppd_phase_map #(.PH_W(PH_W), .CNT_W(CNT_W), .SHIFT_ADD(SHIFT_ADD)) u_phase (
      .phase      (phase_sel),
      .apply      (phase_en),
      .family     (fam_live),
      .steps_log2 (nlog_live),
      .offset     (off_live)
   );

   ppd_counter #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sync_load),
      .ratio_in  (ratio_live),
      .high_in   (high_live),
      .offset_in (off_live),
      .enable    (bank_en),
      .pos       (cnt_q),
      .ratio_cur (ratio_q),
      .level     (div_out)
   );
endmodule

// File: rtl/phase_post_divider_chk.sv
module phase_post_divider_chk #(
   parameter int unsigned CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_load,
   input logic             bank_en,
   input logic             div_out,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] ratio_q,
   input logic [CNT_W-1:0] off_live
);
   // R1: output held low while reset is asserted
   always @(posedge clk) begin
      if (!rst_n) a_r1_low_in_reset: assert (!div_out);
   end

   // R10: a disabled bank is low after the edge
   a_r10_bank_off: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |=> !div_out);

   // R5: sync preloads the counter with the offset presented on that edge
   a_r5_preload: assert property (@(posedge clk) disable iff (!rst_n)
      sync_load |=> (cnt == $past(off_live)));

   // R11: captured ratio only moves on a sync pulse
   a_r11_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_load |=> $stable(ratio_q));

   // R4: ratio 1 keeps an enabled bank high every cycle
   a_r4_unity_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q == CNT_W'(1) && !sync_load && bank_en) |=> div_out);

   // R4: position stays inside the period
   a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio_q);
endmodule

bind phase_post_divider phase_post_divider_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_load (sync_load),
   .bank_en   (bank_en),
   .div_out   (div_out),
   .cnt       (cnt_q),
   .ratio_q   (ratio_q),
   .off_live  (off_live)
);

// File: tb/test_phase_post_divider.sv
module test_phase_post_divider;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sync_load;
   logic [3:0] ratio_sel;
   logic [4:0] phase_sel;
   logic       phase_en;
   logic       bank_en;
   logic       div_out;

   int n_vec = 0;
   int n_bad = 0;
   int m_ratio, m_high, m_off, m_t;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_post_divider i_phase_post_divider (
      .clk(clk), .rst_n(rst_n), .sync_load(sync_load), .ratio_sel(ratio_sel),
      .phase_sel(phase_sel), .phase_en(phase_en), .bank_en(bank_en), .div_out(div_out)
   );

   function automatic int b_ratio(input logic [3:0] c);
      case (c)
         4'd1: return 2;   4'd2: return 4;   4'd3: return 5;
         4'd4: return 8;   4'd5: return 10;  4'd6: return 16;
         4'd7: return 20;  4'd8: return 32;  4'd9: return 40;
         4'd10: return 80;
         default: return 1;
      endcase
   endfunction

   function automatic int b_high(input int r);
      if (r == 1) return 1;
      if (r == 5) return 2;
      return r / 2;
   endfunction

   function automatic int b_off(input logic [3:0] c, input logic [4:0] ph, input logic pe);
      int r = b_ratio(c);
      if (!pe) return 0;
      if (r % 5 == 0) return 5 * ((int'(ph) / 2) % (r / 5));
      return int'(ph) % r;
   endfunction

   // One clock: advance the model for the coming edge, then compare after it
   task automatic cyc(input string tag);
      logic exp;
      if (sync_load) begin
         m_ratio = b_ratio(ratio_sel);
         m_high  = b_high(m_ratio);
         m_off   = b_off(ratio_sel, phase_sel, phase_en);
         m_t     = 0;
      end else begin
         m_t++;
      end
      exp = bank_en && (((m_t + m_off) % m_ratio) < m_high);
      @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (div_out !== exp) begin
         n_bad++;
         $display("FAIL %s: div_out=%0b expected %0b (t=%0d)", tag, div_out, exp, $time);
      end
   endtask

   task automatic seg(input string tag, input logic [3:0] c, input logic [4:0] ph,
                      input logic pe, input int n);
      ratio_sel = c; phase_sel = ph; phase_en = pe; sync_load = 1'b1;
      cyc(tag);
      sync_load = 1'b0;
      repeat (n - 1) cyc(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; sync_load = 1'b0; ratio_sel = 4'd0; phase_sel = '0;
      phase_en = 1'b1; bank_en = 1'b1;
      m_ratio = 1; m_high = 1; m_off = 0; m_t = 0;
      // R1: low during reset
      repeat (3) begin
         @(negedge clk);
         n_vec++;
         if (div_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: div_out=%0b expected 0 in reset", div_out);
         end
      end
      rst_n = 1'b1;
      repeat (4) cyc("R1");
      // R11: new settings without a sync pulse leave ratio 1 running
      ratio_sel = 4'd4; phase_sel = 5'd3;
      repeat (10) cyc("R11");
      // R2: each code with zero phase
      for (int c = 0; c <= 10; c++) seg("R2", 4'(c), 5'd0, 1'b1, 2 * b_ratio(4'(c)) + 3);
      // R4: odd ratio and a wide even ratio
      seg("R4", 4'd3, 5'd0, 1'b1, 17);
      seg("R4", 4'd6, 5'd0, 1'b1, 40);
      // R3: unused codes
      for (int c = 11; c <= 15; c++) seg("R3", 4'(c), 5'd31, 1'b1, 4);
      // R5: lead visible from the first edge
      seg("R5", 4'd1, 5'd1, 1'b1, 6);
      seg("R5", 4'd6, 5'd7, 1'b1, 34);
      // R6: power-of-two masking
      seg("R6", 4'd2, 5'd3, 1'b1, 10);
      seg("R6", 4'd2, 5'd31, 1'b1, 10);
      seg("R6", 4'd8, 5'd19, 1'b1, 70);
      // R7: multiple-of-five, bit 0 skipped
      seg("R7", 4'd5, 5'd2, 1'b1, 22);
      seg("R7", 4'd5, 5'd3, 1'b1, 22);
      seg("R7", 4'd10, 5'd23, 1'b1, 170);
      seg("R7", 4'd10, 5'd31, 1'b1, 170);
      // R8: ratios without phase adjustment
      seg("R8", 4'd0, 5'd31, 1'b1, 5);
      seg("R8", 4'd3, 5'd31, 1'b1, 12);
      // R9: phase disabled
      seg("R9", 4'd8, 5'd9, 1'b0, 40);
      // R10: bank disable while counter keeps running
      seg("R10", 4'd4, 5'd2, 1'b1, 5);
      bank_en = 1'b0;
      repeat (11) cyc("R10");
      bank_en = 1'b1;
      repeat (12) cyc("R10");
      // Random mix of settings, silent changes and enable toggles
      for (int s = 0; s < 90; s++) begin
         logic [3:0] c;
         int n;
         c = 4'($urandom_range(0, 15));
         n = 2 * b_ratio(c) + int'($urandom_range(1, 20));
         seg("RND", c, 5'($urandom), ($urandom_range(0, 7) != 0), 1);
         for (int i = 1; i < n; i++) begin
            if ($urandom_range(0, 15) == 0) bank_en = ~bank_en;
            if ($urandom_range(0, 9) == 0) begin
               ratio_sel = 4'($urandom); phase_sel = 5'($urandom); phase_en = 1'($urandom);
            end
            cyc("RND R11");
         end
         bank_en = 1'b1;
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule